// File: doc/BRIEF.md
# Edge-Interrupting Digital Line Bank

This block controls a bank of 64 digital lines and is accessed through a small 32-bit register bus. Each line has an output value bit and an output-enable bit. With its enable at 1 the line drives its value, and with its enable at 0 it is tri-stated. The receiver on every line stays active at all times. A synchronized copy of each pin can therefore be read back, including on lines the block is driving itself.

Each line has its own rising-edge and falling-edge interrupt enables. An enabled edge sets a sticky per-line status bit. Software clears a status bit by writing 1 to it. The status bits of all lines combine into one active-low, level-sensitive interrupt. A read-only revision word identifies the build. The 64 lines are split into two 32-bit halves: bit i of half h is line 32·h+i.

The bus is a plain register port and not a data stream. It has no back-pressure. A request is taken on every clock edge where `bus_sel` is high. Read data appears, with `bus_rvalid`, in the cycle after the read request.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset all output values, output enables, rising and falling enables and status bits are 0. `pad_oe` and `pad_out` are all 0 and `irq_n` is 1.
- R2: Word addresses 0/1 hold the output values and 2/3 hold the output enables, for half 0 and half 1. `pad_out` and `pad_oe` show these bits line by line. They change only after a write.
- R3: Addresses 4/5 return each pin's level after a two-flop synchronizer. This includes lines the block drives, so a driven line reads back its own level.
- R4: Addresses 6/7 hold the rising-edge enables. A 0-to-1 change on a line whose rising enable is set sets that line's status bit. An edge on a line with no matching enable leaves status unchanged.
- R5: Addresses 8/9 hold the falling-edge enables. A 1-to-0 change on a line whose falling enable is set sets its status bit. With both enables set, either edge sets the bit.
- R6: Status is read at addresses 10/11. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and status never clears without a write.
- R7: If an enabled edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `irq_n` is 0 while any status bit in either half is set. It returns to 1 only when every bit has been cleared.
- R9: Address 12 reads the revision word 0x00010300. Writes to addresses 4, 5 and 12 have no effect.
- R10: Addresses 13 to 15 read as zero.
- R11: A read request produces `bus_rvalid` = 1 and the register contents on `bus_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 64 | Pin levels from the receivers |
| pad_out | output | 64 | Per-line drive value |
| pad_oe | output | 64 | Per-line drive enable |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
The bench loops driven outputs back into `pad_in`. A design that gated the receivers while driving would then read zeros on driven lines. It clears a status bit in exactly the cycle a new edge on that line reaches the status logic. A design that lets the clear win would lose that event. It clears the two halves one at a time and checks that `irq_n` stays low until both are clear, which catches an interrupt built from only one half. It also writes zeros into the status register, triggers edges with only the opposite-direction enable set, and writes to read-only addresses. A design that clears on any write, ignores edge direction, or lets read-only words be written would fail these checks.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // Register group, taken from the upper address bits; the low bits pick the half.
  typedef enum logic [2:0] {
    GRP_OUT  = 3'd0,
    GRP_OE   = 3'd1,
    GRP_IN   = 3'd2,
    GRP_RISE = 3'd3,
    GRP_FALL = 3'd4,
    GRP_STAT = 3'd5,
    GRP_REV  = 3'd6,
    GRP_NONE = 3'd7
  } reg_grp_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], pad_in[i]};
    end
    assign level[i] = sh[1];
    assign rise[i]  = sh[1] & ~sh[2];
    assign fall[i]  = ~sh[1] & sh[2];
  end

  // R3
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise & ~$past(pad_in, 2)) == '0);
endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] evt;
  assign evt = (rise & rise_en) | (fall & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | evt;
  end

  // R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          HALVES   = 2,
  parameter logic [31:0] REV_WORD = 32'h0001_0300,
  localparam int NUM_LINES = W * HALVES,
  localparam int HALF_W    = $clog2(HALVES),
  localparam int ADDR_W    = 3 + HALF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [W-1:0]         bus_wdata,
  output logic [W-1:0]         bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic                 irq_n
);
  reg_grp_e          grp;
  logic [HALF_W-1:0] half;
  logic              wr_hit;
  assign grp    = reg_grp_e'(bus_addr[ADDR_W-1 -: 3]);
  assign half   = bus_addr[HALF_W-1:0];
  assign wr_hit = bus_sel && bus_wr;

  logic [HALVES-1:0][W-1:0] out_q, oe_q, rise_q, fall_q, stat_q;
  logic [NUM_LINES-1:0]     level, rise, fall;

  gpio_edge_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .level(level), .rise(rise), .fall(fall)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic         hit;
    logic [W-1:0] clr;
    assign hit = wr_hit && (half == HALF_W'(h));
    assign clr = (hit && grp == GRP_STAT) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[h]  <= '0;
        oe_q[h]   <= '0;
        rise_q[h] <= '0;
        fall_q[h] <= '0;
      end else if (hit) begin
        case (grp)
          GRP_OUT:  out_q[h]  <= bus_wdata;
          GRP_OE:   oe_q[h]   <= bus_wdata;
          GRP_RISE: rise_q[h] <= bus_wdata;
          GRP_FALL: fall_q[h] <= bus_wdata;
          default: ;
        endcase
      end
    end

    gpio_edge_stat #(.W(W)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .rise(rise[h*W +: W]), .fall(fall[h*W +: W]),
      .rise_en(rise_q[h]), .fall_en(fall_q[h]),
      .clr(clr), .stat(stat_q[h])
    );
  end

  logic [NUM_LINES-1:0] level_v;
  assign level_v = level;

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (grp)
      GRP_OUT:  rd_mux = out_q[half];
      GRP_OE:   rd_mux = oe_q[half];
      GRP_IN:   rd_mux = level_v[half*W +: W];
      GRP_RISE: rd_mux = rise_q[half];
      GRP_FALL: rd_mux = fall_q[half];
      GRP_STAT: rd_mux = stat_q[half];
      GRP_REV:  if (half == '0) rd_mux = REV_WORD;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q;
  assign irq_n   = ~(|stat_q);

  // R2
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(pad_out) && $stable(pad_oe)));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|{rise, fall}));

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);
endmodule

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {write, addr, data, expected}
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 4'd0,  32'hA5A5_0F0F, 32'h0},           // R2
    {1'b1, 4'd1,  32'h1234_5678, 32'h0},
    {1'b1, 4'd2,  32'hFFFF_0000, 32'h0},
    {1'b1, 4'd3,  32'h0000_FFFF, 32'h0},
    {1'b0, 4'd0,  32'h0,         32'hA5A5_0F0F},
    {1'b0, 4'd1,  32'h0,         32'h1234_5678},
    {1'b0, 4'd2,  32'h0,         32'hFFFF_0000},
    {1'b0, 4'd3,  32'h0,         32'h0000_FFFF},
    {1'b1, 4'd6,  32'hDEAD_BEEF, 32'h0},           // R4 enable storage
    {1'b0, 4'd6,  32'h0,         32'hDEAD_BEEF},
    {1'b1, 4'd9,  32'hCAFE_F00D, 32'h0},           // R5 enable storage
    {1'b0, 4'd9,  32'h0,         32'hCAFE_F00D},
    {1'b1, 4'd12, 32'hFFFF_FFFF, 32'h0},           // R9 write ignored
    {1'b0, 4'd12, 32'h0,         32'h0001_0300},   // R9
    {1'b0, 4'd13, 32'h0,         32'h0},           // R10
    {1'b0, 4'd15, 32'h0,         32'h0}            // R10
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_rvalid, irq_n;
  logic [63:0] ext_in = '0, pad_in, pad_out, pad_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  gpio_edge_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk("R11", "rvalid", 64'(bus_rvalid), 64'd1);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "pad_oe", pad_oe, 64'h0);
    chk("R1", "irq_n", 64'(irq_n), 64'd1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][67:64], d);
        chk((VEC[i][67:64] >= 4'd12) ? "R9/R10" : "R2", "table read",
            64'(d), 64'(VEC[i][31:0]));
      end
    end
    chk("R2", "pad_out", pad_out, 64'h1234_5678_A5A5_0F0F);
    chk("R2", "pad_oe", pad_oe, 64'h0000_FFFF_FFFF_0000);

    // R1: reset returns everything to zero
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "pad_out", pad_out, 64'h0);
    chk("R1", "pad_oe", pad_oe, 64'h0);
    chk("R1", "irq_n", 64'(irq_n), 64'd1);
    for (int a = 0; a < 12; a++) begin
      if (a == 4 || a == 5) continue;
      rd(4'(a), d);
      chk("R1", "register", 64'(d), 64'h0);
    end

    // R3: synchronized input readback, also on a driven line
    ext_in[3] = 1; ext_in[40] = 1;
    settle();
    rd(4'd4, d); chk("R3", "in0", 64'(d), 64'h8);
    rd(4'd5, d); chk("R3", "in1", 64'(d), 64'h100);
    wr(4'd0, 32'h80); wr(4'd2, 32'h80);
    settle();
    rd(4'd4, d); chk("R3", "in0 driven", 64'(d), 64'h88);
    wr(4'd4, 32'h0); wr(4'd5, 32'hFFFF_FFFF); // R9 read-only input words
    rd(4'd4, d); chk("R9", "in0 after write", 64'(d), 64'h88);
    rd(4'd5, d); chk("R9", "in1 after write", 64'(d), 64'h100);
    rd(4'd10, d); chk("R4", "no status without enable", 64'(d), 64'h0);

    // R4: rising edge, enabled line 4 vs disabled line 5
    wr(4'd6, 32'h10);
    ext_in[4] = 1; ext_in[5] = 1;
    settle();
    rd(4'd10, d); chk("R4", "stat0 rise", 64'(d), 64'h10);
    chk("R8", "irq_n low", 64'(irq_n), 64'd0);

    // R6: write 0 keeps, write 1 clears
    wr(4'd10, 32'h0);
    rd(4'd10, d); chk("R6", "stat0 after write 0", 64'(d), 64'h10);
    wr(4'd10, 32'h10);
    rd(4'd10, d); chk("R6", "stat0 after clear", 64'(d), 64'h0);
    chk("R8", "irq_n released", 64'(irq_n), 64'd1);

    // R4: falling edge with only the rising enable set
    ext_in[4] = 0;
    settle();
    rd(4'd10, d); chk("R4", "fall on rise-only line", 64'(d), 64'h0);

    // R5: both enables on line 34
    wr(4'd7, 32'h4); wr(4'd9, 32'h4);
    ext_in[34] = 1;
    settle();
    rd(4'd11, d); chk("R5", "stat1 rise", 64'(d), 64'h4);
    wr(4'd11, 32'h4);
    ext_in[34] = 0;
    settle();
    rd(4'd11, d); chk("R5", "stat1 fall", 64'(d), 64'h4);

    // R8: both halves pending, clear one at a time
    ext_in[4] = 1;
    settle();
    chk("R8", "irq_n two pending", 64'(irq_n), 64'd0);
    wr(4'd11, 32'h4);
    chk("R8", "irq_n half0 pending", 64'(irq_n), 64'd0);
    wr(4'd10, 32'h10);
    chk("R8", "irq_n all clear", 64'(irq_n), 64'd1);

    // R7: clear and new edge in the same cycle
    wr(4'd8, 32'h10);
    ext_in[4] = 0;
    settle();
    rd(4'd10, d); chk("R5", "stat0 fall", 64'(d), 64'h10);
    ext_in[4] = 1;
    repeat (2) @(negedge clk);
    wr(4'd10, 32'h10);
    rd(4'd10, d); chk("R7", "event beats clear", 64'(d), 64'h10);
    chk("R7", "irq_n", 64'(irq_n), 64'd0);
    wr(4'd10, 32'h10);
    rd(4'd10, d); chk("R6", "final clear", 64'(d), 64'h0);

    done = 1;
    finish_run();
  end
endmodule